// File: doc/BRIEF.md
# Sequential Radix-2 Booth Signed Multiplier

This block multiplies two signed two's-complement operands of `W` bits (32 by default) and returns the full signed product of `2W` bits. It works serially and retires one multiplier bit per clock. The multiplier bit in the current lowest position and the bit that was shifted out on the step before are recoded together. The pair selects one of three actions on a running accumulator: add the multiplicand, subtract it, or leave the accumulator alone. After that action, the accumulator, the multiplier register and the shifted-out bit move one place right together as a single arithmetic-shift chain.

A caller drives both operands and raises `start` for one cycle while the block is idle. The block then reports `busy` for exactly `W` clock cycles. It pulses `done` for one cycle when the last step has been taken. At that point `product` holds the accumulator in the upper half and the multiplier register in the lower half, and it keeps that value until the next accepted start. Negative multipliers need no correction step. The most negative operand value is handled by giving the accumulator one guard bit above `W`, so subtracting the most negative multiplicand cannot wrap.

Top module: `booth_mul_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` sampled high while `busy` is 0 loads the operands and makes `busy` 1 on the next cycle. `product` at `done` then equals the signed product of `multiplicand` and `multiplier`, read as a `2W`-bit two's-complement number.
- R3: If `start` is accepted at clock edge k, `busy` stays 1 until edge k+W. After edge k+W, `done` is 1 and `busy` is 0.
- R4: `done` is high for exactly one cycle per accepted start.
- R5: A `start` raised while `busy` is 1 is ignored. The running product is unaffected, and no extra `done` follows.
- R6: Every sign combination gives the correct signed product, including negative multipliers (for example -5 x -3 = 15, -7 x 3 = -21, 7 x -3 = -21).
- R7: The most negative value (0x80000000 at W=32) is multiplied correctly as multiplicand, as multiplier, or as both. Both together give 2^(2W-2).
- R8: Between `done` and the next accepted start, `product` holds its value.
- R9: Zero operands give a zero product. Alternating bit patterns, which make the recoding switch between add and subtract on every step, give the correct product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a multiply; accepted only while idle |
| multiplicand | input | W | Signed multiplicand, sampled on the accepting edge |
| multiplier | input | W | Signed multiplier, sampled on the accepting edge |
| busy | output | 1 | High while recode/shift steps are running |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | 2W | Signed product: accumulator (high) and multiplier register (low) |

## Verification
The bound checker watches the control timing on every cycle: the reset state, `busy` rising after an accepted start, the latency of exactly `W` steps (counted by the checker's own counter), the single-cycle `done` pulse, `busy` staying up when a start arrives mid-operation, and `product` holding while idle. The arithmetic itself can only be shown by the bench's scenarios. Its scoreboard compares each `done` against a signed reference multiply across all sign combinations, the most negative operand in each position, zeros, alternating patterns and pseudo-random pairs. The bench also shows that an intruding start changes neither the pending result nor the count of `done` pulses.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // Action chosen by the recoder for one step
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_ADD  = 2'd1,
    STEP_SUB  = 2'd2
  } step_op_e;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic     lsb_now,
  input  logic     lsb_prev,
  output step_op_e op
);

  // Pair (current lsb, previously shifted-out bit):
  // 1,0 -> start of a run of ones -> subtract
  // 0,1 -> end of a run of ones   -> add
  always_comb begin
    unique case ({lsb_now, lsb_prev})
      2'b10:   op = STEP_SUB;
      2'b01:   op = STEP_ADD;
      default: op = STEP_HOLD;
    endcase
  end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int AW = 33
) (
  input  logic [AW-1:0] acc,
  input  logic [AW-1:0] mcand,
  input  step_op_e      op,
  output logic [AW-1:0] result
);

  logic [AW-1:0] operand;
  logic          carry_in;

  // One adder serves both directions: subtraction inverts and adds one
  always_comb begin
    unique case (op)
      STEP_ADD: begin operand = mcand;       carry_in = 1'b0; end
      STEP_SUB: begin operand = ~mcand;      carry_in = 1'b1; end
      default:  begin operand = '0;          carry_in = 1'b0; end
    endcase
    result = acc + operand + AW'(carry_in);
  end

endmodule

// File: rtl/booth_step_counter.sv
module booth_step_counter #(
  parameter int STEPS = 32,
  localparam int CW   = $clog2(STEPS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  output logic [CW-1:0] remaining,
  output logic          last_step
);

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
    end else if (load) begin
      remaining <= CW'(STEPS);
    end else if (step && remaining != '0) begin
      remaining <= remaining - CW'(1);
    end
  end

  assign last_step = (remaining == CW'(1));

endmodule

// File: rtl/booth_mul_seq.sv
module booth_mul_seq
  import booth_pkg::*;
#(
  parameter int W   = 32,
  localparam int AW = W + 1,
  localparam int PW = 2 * W,
  localparam int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [W-1:0]  multiplicand,
  input  logic [W-1:0]  multiplier,
  output logic          busy,
  output logic          done,
  output logic [PW-1:0] product
);

  // Accumulator carries one guard bit so that subtracting the most
  // negative multiplicand never wraps.
  logic [AW-1:0] acc_r;
  logic [AW-1:0] mcand_r;
  logic [W-1:0]  mq_r;
  logic          shifted_out_r;

  logic          accept;
  logic          last_step;
  logic [CW-1:0] steps_left;
  step_op_e      op;
  logic [AW-1:0] acc_sum;

  assign accept = start && !busy;

  booth_recode u_recode (
    .lsb_now  (mq_r[0]),
    .lsb_prev (shifted_out_r),
    .op       (op)
  );

  booth_addsub #(.AW(AW)) u_addsub (
    .acc    (acc_r),
    .mcand  (mcand_r),
    .op     (op),
    .result (acc_sum)
  );

  booth_step_counter #(.STEPS(W)) u_count (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .step      (busy),
    .remaining (steps_left),
    .last_step (last_step)
  );

  // Datapath: load, then add/sub followed by arithmetic shift of the chain
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_r         <= '0;
      mcand_r       <= '0;
      mq_r          <= '0;
      shifted_out_r <= 1'b0;
    end else if (accept) begin
      acc_r         <= '0;
      mcand_r       <= {multiplicand[W-1], multiplicand};
      mq_r          <= multiplier;
      shifted_out_r <= 1'b0;
    end else if (busy) begin
      acc_r         <= {acc_sum[AW-1], acc_sum[AW-1:1]};
      mq_r          <= {acc_sum[0], mq_r[W-1:1]};
      shifted_out_r <= mq_r[0];
    end
  end

  // Control: busy for W steps, then a single done pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
      end else if (busy && last_step) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  // The final result fits in PW bits; the guard bit is dropped here.
  assign product = {acc_r[W-1:0], mq_r};

  logic unused_ok;
  assign unused_ok = ^steps_left;

endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
  parameter int W   = 32,
  localparam int PW = 2 * W,
  localparam int LW = $clog2(W + 2) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [PW-1:0] product
);

  // Independent step counter for the latency window
  logic [LW-1:0] lat_cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      lat_cnt <= '0;
    end else if (start && !busy) begin
      lat_cnt <= '0;
    end else if (busy) begin
      lat_cnt <= lat_cnt + LW'(1);
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !done && product == '0)); // R1
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R2
  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_cnt == LW'(W))); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start && lat_cnt < LW'(W - 1)) |=> (busy && !done)); // R5
  AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(product)); // R8

endmodule

bind booth_mul_seq booth_mul_chk #(.W(W)) u_booth_mul_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .product (product)
);

// File: tb/test_booth_mul_seq.sv
module test_booth_mul_seq;

  localparam int W  = 32;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  multiplicand = '0;
  logic [W-1:0]  multiplier = '0;
  logic          busy;
  logic          done;
  logic [PW-1:0] product;

  booth_mul_seq #(.W(W)) i_booth_mul_seq (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .busy         (busy),
    .done         (done),
    .product      (product)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Scoreboard queues
  logic [PW-1:0] exp_q[$];
  int            t_q[$];
  string         req_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [PW-1:0] sa, sb, sp;
    sa = $signed({{W{a[W-1]}}, a});
    sb = $signed({{W{b[W-1]}}, b});
    sp = sa * sb;
    return sp;
  endfunction

  // Driver: waits for idle, issues start, pushes the expected result
  task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    @(negedge clk);
    while (busy) @(negedge clk);
    start        = 1'b1;
    multiplicand = a;
    multiplier   = b;
    exp_q.push_back(ref_mul(a, b));
    t_q.push_back(cyc);
    req_q.push_back(req);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2", "busy after accepted start", PW'(busy), PW'(1));
  endtask

  // Monitor: compares every done against the scoreboard head
  bit prev_done = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        check(prev_done == 1'b0, "R4", "done wider than one cycle", PW'(prev_done), PW'(0));
        if (exp_q.size() == 0) begin
          check(1'b0, "R5", "unexpected done", PW'(1), PW'(0));
        end else begin
          logic [PW-1:0] e;
          int            t;
          string         r;
          e = exp_q.pop_front();
          t = t_q.pop_front();
          r = req_q.pop_front();
          check(product == e, r, "product", product, e);
          check(cyc - t == W + 1, "R3", "done latency", PW'(cyc - t), PW'(W + 1));
          check(busy == 1'b0, "R3", "busy low at done", PW'(busy), PW'(0));
        end
      end
      prev_done = done;
    end
  end

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};

  initial begin
    logic [W-1:0]  lcg;
    logic [PW-1:0] held;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0, "R1", "busy/done in reset", PW'({busy, done}), PW'(0));
    check(product == '0, "R1", "product in reset", product, '0);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 0 && done == 0 && product == '0, "R1", "state after reset",
          product, '0);

    // R2: basic positive case, 7 x 3
    run_mul(W'(7), W'(3), "R2");
    // R6: sign combinations
    run_mul(-W'(5), -W'(3), "R6");
    run_mul(-W'(7), W'(3), "R6");
    run_mul(W'(7), -W'(3), "R6");
    run_mul(-W'(1), -W'(1), "R6");
    // R7: most negative operand
    run_mul(MIN_V, MIN_V, "R7");
    run_mul(MIN_V, W'(1), "R7");
    run_mul(W'(1), MIN_V, "R7");
    run_mul(MIN_V, -W'(1), "R7");
    run_mul(-W'(1), MIN_V, "R7");
    run_mul(MIN_V, MAX_V, "R7");
    run_mul(MAX_V, MAX_V, "R7");
    // R9: zeros and alternating patterns
    run_mul('0, W'(12345), "R9");
    run_mul(-W'(9), '0, "R9");
    run_mul({(W/2){2'b01}}, {(W/2){2'b10}}, "R9");
    run_mul({(W/2){2'b10}}, {(W/2){2'b10}}, "R9");
    // R2: pseudo-random pairs
    lcg = W'(32'h1234_5678);
    for (int i = 0; i < 16; i++) begin
      logic [W-1:0] a;
      lcg = lcg * W'(1664525) + W'(1013904223);
      a   = lcg;
      lcg = lcg * W'(1664525) + W'(1013904223);
      run_mul(a, lcg ^ {W{i[0]}}, "R2");
    end
    wait_drain();

    // R8: product holds while idle
    held = product;
    repeat (6) @(negedge clk);
    check(product == held, "R8", "product held while idle", product, held);

    // R5: start while busy is ignored
    run_mul(W'(1000), -W'(77), "R5");
    repeat (4) @(negedge clk);
    start        = 1'b1;
    multiplicand = W'(3);
    multiplier   = W'(3);
    repeat (3) @(negedge clk);
    start = 1'b0;
    wait_drain();
    repeat (W + 5) @(negedge clk);
    check(busy == 1'b0, "R5", "no second operation started", PW'(busy), PW'(0));
    check(exp_q.size() == 0, "R5", "scoreboard empty", PW'(exp_q.size()), PW'(0));

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  // Watchdog
  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule